// File: doc/BRIEF.md
# Eight-Bit I/O Port with Atomic Bit-Set

This block is an 8-bit general-purpose I/O port. Each pin has one direction bit and one output latch bit, and both sit behind a small register bus. A port read does not simply return the latch. Pins configured as inputs report their synchronized external level, and pins configured as outputs report their latch bit.

A separate bit-set request names one bit by a 3-bit index. The port carries out the request as a read-modify-write of the whole byte, in two steps:

1. It takes a snapshot of the port view.
2. It stores that snapshot, with the chosen bit forced high, back into the latch.

Because the snapshot uses the port view, the latch bits of input pins end up holding the pin levels that were sampled. A busy flag covers the two cycles of the sequence, and any request that arrives while the flag is high is dropped.

Top module: `gpio_rmw_port`

## Requirements
- R1: A synchronous active-high reset clears the direction and latch registers and the busy flag. After reset every pin is an input, so pin_oe and pin_out are 0.
- R2: pin_oe equals the direction register. pin_out equals the latch ANDed with the direction register.
- R3: A read at address 0 returns the latch bit for output pins (direction 1). For input pins (direction 0) it returns the pin level after a two-flop synchronizer, so a pin change shows in a read issued two cycles after it. Read data appears on the clock edge that samples bus_rd.
- R4: A read at address 1 returns the direction register. A read at any other address returns 0.
- R5: A bus write at address 0 updates all 8 latch bits, whatever the direction setting.
- R6: An accepted bit-set raises busy for exactly two cycles. In the first cycle the port view is captured. In the second cycle the latch is written with the captured byte, with bit set_idx forced to 1.
- R7: After a bit-set, the latch bits of input pins equal the pin levels captured in the first step. Example: latch 0x80, direction 0x3F, pins 0x40, bit 0 set gives a latch of 0x41.
- R8: A bit-set request made while busy is high is ignored.
- R9: Changing the latch bit of an input pin leaves pin_out unchanged while that pin stays an input.
- R10: When a bus write to address 0 falls in the write cycle of a bit-set, the bit-set value is stored and the bus write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address: 0 is the latch/port view, 1 is direction |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| set_req | input | 1 | Bit-set request |
| set_idx | input | 3 | Index of the bit to set |
| set_busy | output | 1 | Bit-set sequence in progress |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables |

## Verification
A bus write to the latch and the write step of a bit-set can land on the same clock edge. The bench provokes this by raising the write strobe exactly two cycles after an accepted request. It then judges the outcome by reading the latch back: the result must be the bit-set value, not the bus data. A second collision, a fresh request during the busy window, is judged by confirming that only the first request's bit ends up set and that busy drops after two cycles.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

    localparam int PORT_W     = 8;
    localparam int IDX_W      = $clog2(PORT_W);
    localparam int SYNC_DEPTH = 2;
    localparam int ADDR_LATCH = 0;
    localparam int ADDR_DIR   = 1;

    typedef logic [PORT_W-1:0] port_t;
    typedef logic [IDX_W-1:0]  bidx_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

    // Value the port presents to a reader: latch for outputs, pin for inputs.
    function automatic port_t port_view(port_t dir, port_t latch, port_t pins);
        return (dir & latch) | (~dir & pins);
    endfunction

    function automatic port_t with_bit(port_t v, bidx_t i);
        port_t r;
        r    = v;
        r[i] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) chain[0] <= d;
        end else begin : g_next
            always_ff @(posedge clk) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

    if (STAGES == 2) begin : g_chk
        assert_sync_lag_R3: assert property (@(posedge clk) disable iff (rst)
            q == $past(d, 2));
    end
endmodule

// File: rtl/gpio_setbit_seq.sv
module gpio_setbit_seq
    import gpio_rmw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  bidx_t idx,
    input  port_t view,
    output logic  busy,
    output logic  wr_phase,
    output port_t wr_value
);
    seq_state_e state_q;
    bidx_t      idx_q;
    port_t      snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            snap_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (req) begin
                    state_q <= SEQ_READ;
                    idx_q   <= idx;
                end
                SEQ_READ: begin
                    snap_q  <= view;
                    state_q <= SEQ_WRITE;
                end
                SEQ_WRITE: state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != SEQ_IDLE);
    assign wr_phase = (state_q == SEQ_WRITE);
    assign wr_value = with_bit(snap_q, idx_q);

    assert_start_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && req) |=> state_q == SEQ_READ);
    assert_read_then_write_R6: assert property (@(posedge clk) disable iff (rst)
        state_q == SEQ_READ |=> state_q == SEQ_WRITE);
    assert_write_then_idle_R6: assert property (@(posedge clk) disable iff (rst)
        state_q == SEQ_WRITE |=> state_q == SEQ_IDLE);
    assert_idx_held_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(idx_q));
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
    import gpio_rmw_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic              set_req,
    input  logic [IDX_W-1:0]  set_idx,
    output logic              set_busy,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    port_t dir_q, lat_q, pin_s, view, seq_val;
    logic  seq_wr;
    logic  hit_latch, hit_dir;

    assign hit_latch = (bus_addr == ADDR_W'(ADDR_LATCH));
    assign hit_dir   = (bus_addr == ADDR_W'(ADDR_DIR));

    gpio_pin_sync #(.W(PORT_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
    );

    assign view = port_view(dir_q, lat_q, pin_s);

    gpio_setbit_seq u_seq (
        .clk(clk), .rst(rst), .req(set_req), .idx(set_idx), .view(view),
        .busy(set_busy), .wr_phase(seq_wr), .wr_value(seq_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lat_q <= '0;
        end else begin
            if (bus_wr && hit_dir) dir_q <= bus_wdata;
            if (seq_wr)                    lat_q <= seq_val;
            else if (bus_wr && hit_latch)  lat_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          bus_rdata <= '0;
        else if (bus_rd) begin
            if (hit_latch)    bus_rdata <= view;
            else if (hit_dir) bus_rdata <= dir_q;
            else              bus_rdata <= '0;
        end
    end

    assign pin_oe  = dir_q;
    assign pin_out = lat_q & dir_q;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && !set_busy));
    assert_no_drive_on_input_R9: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);
    assert_dir_readback_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit_dir) |=> bus_rdata == $past(pin_oe));
    assert_latch_commit_R10: assert property (@(posedge clk) disable iff (rst)
        seq_wr |=> (pin_out == ($past(seq_val) & pin_oe)));
endmodule

// File: tb/tb_gpio_rmw_port.sv
`timescale 1ns/1ps
module tb_gpio_rmw_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       set_req = 1'b0;
    logic [2:0] set_idx = '0;
    logic       set_busy;
    logic [7:0] pin_in = '0, pin_out, pin_oe;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    gpio_rmw_port dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 busy", {7'd0, set_busy}, 8'h00);
        bus_read(2'd1, v); chk("R1 dir", v, 8'h00);
        bus_read(2'd0, v); chk("R1 port", v, 8'h00);
    endtask

    task automatic t_dir_out();
        logic [7:0] v;
        bus_write(2'd0, 8'hA5);
        bus_write(2'd1, 8'h0F);
        chk("R2 oe", pin_oe, 8'h0F);
        chk("R2 out", pin_out, 8'h05);
        bus_read(2'd1, v); chk("R4 dir read", v, 8'h0F);
        bus_read(2'd2, v); chk("R4 unmapped read", v, 8'h00);
    endtask

    task automatic t_read_view();
        logic [7:0] v;
        pin_in = 8'h3C; wait_n(3);
        bus_read(2'd0, v); chk("R3 mixed view", v, 8'h35);
        pin_in = 8'hC3;
        bus_read(2'd0, v); chk("R3 sync lag", v, 8'h35);
        wait_n(2);
        bus_read(2'd0, v); chk("R3 after sync", v, 8'hC5);
    endtask

    task automatic t_write_all();
        logic [7:0] v;
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h5A);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd0, v); chk("R5 latch all bits", v, 8'h5A);
        chk("R5 out", pin_out, 8'h5A);
    endtask

    task automatic t_input_latch();
        bus_write(2'd1, 8'hF0);
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'h0F);
        chk("R9 input latch no drive", pin_out, 8'h00);
        bus_write(2'd1, 8'hFF);
        chk("R9 latch kept", pin_out, 8'h0F);
    endtask

    task automatic t_example();
        logic [7:0] v;
        bus_write(2'd1, 8'hFF);
        bus_write(2'd0, 8'h80);
        bus_write(2'd1, 8'h3F);
        pin_in = 8'h40; wait_n(3);
        bus_read(2'd0, v); chk("R7 port view", v, 8'h40);
        set_idx = 3'd0; set_req = 1'b1;
        @(negedge clk); set_req = 1'b0;
        chk("R6 busy c1", {7'd0, set_busy}, 8'h01);
        @(negedge clk);
        chk("R6 busy c2", {7'd0, set_busy}, 8'h01);
        @(negedge clk);
        chk("R6 busy end", {7'd0, set_busy}, 8'h00);
        chk("R7 out", pin_out, 8'h01);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd0, v); chk("R7 latch", v, 8'h41);
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        bus_write(2'd0, 8'h00);
        set_idx = 3'd1; set_req = 1'b1;
        @(negedge clk);
        set_idx = 3'd6;
        @(negedge clk); set_req = 1'b0;
        @(negedge clk);
        chk("R8 busy done", {7'd0, set_busy}, 8'h00);
        bus_read(2'd0, v); chk("R8 only first bit", v, 8'h02);
        chk("R8 no restart", {7'd0, set_busy}, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        bus_write(2'd0, 8'h00);
        set_idx = 3'd3; set_req = 1'b1;
        @(negedge clk); set_req = 1'b0;
        @(negedge clk);
        bus_write(2'd0, 8'hAA);
        bus_read(2'd0, v); chk("R10 bit-set wins", v, 8'h08);
        bus_write(2'd0, 8'hAA);
        bus_read(2'd0, v); chk("R5 later write", v, 8'hAA);
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir_out();
        t_read_view();
        t_write_all();
        t_input_latch();
        t_example();
        t_ignore();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule